// File: doc/BRIEF.md
# Burst Phase Picker

This block recovers upstream burst data whose phase relative to the local bit clock is unknown. On every bit-clock cycle it takes in a vector of samples of the serial line, one per evenly spaced sub-bit phase, with index 0 the earliest phase of the cycle. At the start of each burst the sender transmits an alternating 1/0 preamble. The block finds the sub-bit position where the data changes and checks that this position is consistent across a run of transitions. It then chooses the phase that lies half a bit away from that edge.

Once the phase is chosen, the sample from that phase goes through a register pipeline to a single serial output, and a lock flag is raised. The choice stays fixed until the next synchronous burst reset. Until lock, the serial output is held at 0. The bit clock itself is never altered: only the selected sample index changes, and only between bursts.

Top module: `burst_phase_picker`

## Requirements
- R1: While `rst_burst` is high at a rising clock edge, that edge clears `lock_o`, `phase_o` and `sdo_o` to 0 and discards the current sample vector.
- R2: On lock, `phase_o` becomes (edge position + NPH/2) mod NPH. The edge position is taken from the last transition of the qualifying run, and it is the index i where sample i differs from the sample just before it in time.
- R3: Lock happens after LOCK_RUN consecutive vectors that each contain exactly one transition, with each edge position within ±1 phase (mod NPH) of the first edge of the run. With EDGE_TOL=0 the positions must match exactly. If the LOCK_RUN-th such vector arrives at edge t, `lock_o` rises after edge t+1+PIPE_STAGES.
- R4: The run count restarts on a vector with no transition, on a vector with more than one transition, or on an edge outside the tolerance. An out-of-tolerance edge starts a new run of length 1 at its own position.
- R5: Once valid, `sdo_o` after edge v+PIPE_STAGES equals the sample at index `phase_o` of the vector captured at edge v.
- R6: `sdo_o` is 0 whenever `lock_o` is 0.
- R7: `lock_o` stays high until the next burst reset.
- R8: While locked, `phase_o` does not change, even if later edges move.
- R9: Sample index 0 follows the last index of the previous vector. A change between them is an edge at position 0, and tolerance wraps between positions NPH-1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_burst | input | 1 | Synchronous burst reset, active high |
| samp_i | input | NPH | Sub-bit samples of the serial line, index 0 earliest |
| sdo_o | output | 1 | Retimed serial data |
| lock_o | output | 1 | Phase acquired and output data valid |
| phase_o | output | log2(NPH) | Selected sample phase |

## Verification
The bench uses the defaults: NPH=8, LOCK_RUN=12, PIPE_STAGES=4 and EDGE_TOL=1. With LOCK_RUN=12, a 13-bit alternating preamble locks on its 12th transition and hands over data from the 13th bit. This makes it possible to compare the exact lock edge against the formula for every one of the eight sub-bit offsets. Offsets 4 to 7 move each payload bit by one extra cycle compared with offsets 0 to 3, so both output latencies are checked. The ±1 tolerance is exercised around the 7/0 wrap, as are run restarts caused by far edges and by missing transitions.

// File: rtl/bpp_pkg.sv
package bpp_pkg;

   typedef enum logic [1:0] {
      ACQ_IDLE   = 2'd0,
      ACQ_RUN    = 2'd1,
      ACQ_LOCKED = 2'd2
   } acq_state_t;

endpackage

// File: rtl/bpp_edge_find.sv
module bpp_edge_find #(
   parameter int NPH = 8,
   parameter int IW  = 3
) (
   input  logic [NPH-1:0] vec_i,
   input  logic           prior_i,
   output logic [IW-1:0]  pos_o,
   output logic           one_o
);

   logic [NPH-1:0] diff;

   genvar gi;
   generate
      for (gi = 0; gi < NPH; gi++) begin : g_diff
         if (gi == 0) begin : g_wrap
            assign diff[gi] = vec_i[gi] ^ prior_i;
         end else begin : g_inner
            assign diff[gi] = vec_i[gi] ^ vec_i[gi-1];
         end
      end
   endgenerate

   always_comb begin
      pos_o = '0;
      for (int i = 0; i < NPH; i++) begin
         if (diff[i]) pos_o = IW'(i);
      end
   end

   assign one_o = ($countones(diff) == 1);

endmodule

// File: rtl/bpp_lock_ctl.sv
module bpp_lock_ctl
   import bpp_pkg::*;
#(
   parameter int NPH      = 8,
   parameter int IW       = 3,
   parameter int LOCK_RUN = 12,
   parameter int EDGE_TOL = 1,
   parameter int CW       = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [IW-1:0] pos_i,
   input  logic          one_i,
   output logic          lock_o,
   output logic [IW-1:0] sel_o,
   output logic [CW-1:0] run_o
);

   acq_state_t    st_q, st_d;
   logic [IW-1:0] ref_q, ref_d;
   logic [IW-1:0] sel_q, sel_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          near;
   logic [IW-1:0] gap;

   assign gap = pos_i - ref_q;

   generate
      if (EDGE_TOL == 0) begin : g_exact
         assign near = (gap == '0);
      end else begin : g_tol
         assign near = (gap == '0) || (gap == IW'(1)) || (gap == '1);
      end
   endgenerate

   always_comb begin
      st_d  = st_q;
      ref_d = ref_q;
      sel_d = sel_q;
      cnt_d = cnt_q;
      if (st_q != ACQ_LOCKED) begin
         if (one_i && (st_q == ACQ_RUN) && near) begin
            cnt_d = cnt_q + CW'(1);
         end else if (one_i) begin
            cnt_d = CW'(1);
            ref_d = pos_i;
         end else begin
            cnt_d = '0;
         end
         st_d = (cnt_d == '0) ? ACQ_IDLE : ACQ_RUN;
         if (cnt_d == CW'(LOCK_RUN)) begin
            st_d  = ACQ_LOCKED;
            sel_d = pos_i + IW'(NPH / 2);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= ACQ_IDLE;
         ref_q <= '0;
         sel_q <= '0;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         ref_q <= ref_d;
         sel_q <= sel_d;
         cnt_q <= cnt_d;
      end
   end

   assign lock_o = (st_q == ACQ_LOCKED);
   assign sel_o  = sel_q;
   assign run_o  = cnt_q;

endmodule

// File: rtl/bpp_steer_pipe.sv
module bpp_steer_pipe #(
   parameter int NPH   = 8,
   parameter int IW    = 3,
   parameter int DEPTH = 4
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [NPH-1:0] vec_i,
   input  logic [IW-1:0]  sel_i,
   input  logic           en_i,
   output logic           bit_o,
   output logic           vld_o
);

   logic           pick;
   logic [DEPTH-1:0] dq;
   logic [DEPTH-1:0] vq;

   assign pick = en_i & vec_i[sel_i];

   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) begin
               dq <= '0;
               vq <= '0;
            end else begin
               dq <= pick;
               vq <= en_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst) begin
               dq <= '0;
               vq <= '0;
            end else begin
               dq <= {dq[DEPTH-2:0], pick};
               vq <= {vq[DEPTH-2:0], en_i};
            end
         end
      end
   endgenerate

   assign bit_o = dq[DEPTH-1] & vq[DEPTH-1];
   assign vld_o = vq[DEPTH-1];

endmodule

// File: rtl/burst_phase_picker.sv
module burst_phase_picker #(
   parameter int NPH         = 8,
   parameter int LOCK_RUN    = 12,
   parameter int PIPE_STAGES = 4,
   parameter int EDGE_TOL    = 1
) (
   input  logic                   clk,
   input  logic                   rst_burst,
   input  logic [NPH-1:0]         samp_i,
   output logic                   sdo_o,
   output logic                   lock_o,
   output logic [$clog2(NPH)-1:0] phase_o
);

   localparam int IW = $clog2(NPH);
   localparam int CW = $clog2(LOCK_RUN + 1);

   generate
      if (NPH < 4 || (1 << IW) != NPH) begin : g_bad_nph
         $error("NPH must be a power of two, at least 4");
      end
      if (LOCK_RUN < 1) begin : g_bad_run
         $error("LOCK_RUN must be at least 1");
      end
      if (PIPE_STAGES < 1) begin : g_bad_pipe
         $error("PIPE_STAGES must be at least 1");
      end
      if (EDGE_TOL < 0 || EDGE_TOL > 1) begin : g_bad_tol
         $error("EDGE_TOL must be 0 or 1");
      end
   endgenerate

   logic [NPH-1:0] samp_q;
   logic           prior_q;
   logic [IW-1:0]  edge_pos;
   logic           edge_one;
   logic           lock_core;
   logic [IW-1:0]  sel;
   logic [CW-1:0]  run_cnt;

   always_ff @(posedge clk) begin
      if (rst_burst) begin
         samp_q  <= '0;
         prior_q <= 1'b0;
      end else begin
         samp_q  <= samp_i;
         prior_q <= samp_q[NPH-1];
      end
   end

   bpp_edge_find #(
      .NPH (NPH),
      .IW  (IW)
   ) u_edge (
      .vec_i   (samp_q),
      .prior_i (prior_q),
      .pos_o   (edge_pos),
      .one_o   (edge_one)
   );

   bpp_lock_ctl #(
      .NPH      (NPH),
      .IW       (IW),
      .LOCK_RUN (LOCK_RUN),
      .EDGE_TOL (EDGE_TOL),
      .CW       (CW)
   ) u_lock (
      .clk    (clk),
      .rst    (rst_burst),
      .pos_i  (edge_pos),
      .one_i  (edge_one),
      .lock_o (lock_core),
      .sel_o  (sel),
      .run_o  (run_cnt)
   );

   bpp_steer_pipe #(
      .NPH   (NPH),
      .IW    (IW),
      .DEPTH (PIPE_STAGES)
   ) u_pipe (
      .clk   (clk),
      .rst   (rst_burst),
      .vec_i (samp_q),
      .sel_i (sel),
      .en_i  (lock_core),
      .bit_o (sdo_o),
      .vld_o (lock_o)
   );

   assign phase_o = sel;

endmodule

// File: rtl/bpp_checker.sv
module bpp_checker #(
   parameter int NPH         = 8,
   parameter int LOCK_RUN    = 12,
   parameter int PIPE_STAGES = 4,
   parameter int RUN_W       = 4
) (
   input logic                   clk,
   input logic                   rst,
   input logic                   sdo,
   input logic                   lock,
   input logic [$clog2(NPH)-1:0] phase,
   input logic                   lock_core,
   input logic [RUN_W-1:0]       run_cnt
);

   localparam int SW = $clog2(PIPE_STAGES + 2) + 1;

   logic          rst_d;
   logic [SW-1:0] since;

   always @(posedge clk) rst_d <= rst;

   always_ff @(posedge clk) begin
      if (rst) since <= '0;
      else if (lock_core && since <= SW'(PIPE_STAGES)) since <= since + SW'(1);
   end

   always @(negedge clk) begin
      if (rst_d) begin
         assert_reset_clear_R1: assert (!lock && !sdo && phase == '0)
            else $error("outputs not cleared by burst reset");
      end
   end

   assert_run_before_lock_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(lock_core) |-> $past(run_cnt) == RUN_W'(LOCK_RUN - 1));

   assert_lock_latency_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(lock) |-> since == SW'(PIPE_STAGES));

   assert_quiet_unlocked_R6: assert property (@(posedge clk) disable iff (rst)
      !lock |-> !sdo);

   assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      lock |=> lock);

   assert_phase_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (lock && $past(lock)) |-> $stable(phase));

endmodule

bind burst_phase_picker bpp_checker #(
   .NPH         (NPH),
   .LOCK_RUN    (LOCK_RUN),
   .PIPE_STAGES (PIPE_STAGES),
   .RUN_W       ($clog2(LOCK_RUN + 1))
) u_chk (
   .clk       (clk),
   .rst       (rst_burst),
   .sdo       (sdo_o),
   .lock      (lock_o),
   .phase     (phase_o),
   .lock_core (lock_core),
   .run_cnt   (run_cnt)
);

// File: tb/burst_phase_picker_tb.sv
module burst_phase_picker_tb;

   localparam int NPH = 8;
   localparam int RUN = 12;
   localparam int PS  = 4;
   localparam int IW  = 3;
   localparam int P0  = 4;

   // offset, expected phase, extra bit delay
   localparam int OFF_TAB [8][3] = '{
      '{0, 4, 0}, '{1, 5, 0}, '{2, 6, 0}, '{3, 7, 0},
      '{4, 0, 1}, '{5, 1, 1}, '{6, 2, 1}, '{7, 3, 1}
   };

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [NPH-1:0] samp = '0;
   logic           sdo;
   logic           lock;
   logic [IW-1:0]  phase;

   int   errs = 0;
   int   checks = 0;
   int   cyc = 0;
   int   wd = 0;
   int   lock_at = 1000;
   int   dly = 0;
   int   exp_ph = 0;
   logic prev_bit = 1'b0;
   logic bits_h [0:255];
   logic [15:0] lfsr;

   always #10 clk = ~clk;

   burst_phase_picker #(
      .NPH(NPH), .LOCK_RUN(RUN), .PIPE_STAGES(PS), .EDGE_TOL(1)
   ) u_dut (
      .clk(clk), .rst_burst(rst), .samp_i(samp),
      .sdo_o(sdo), .lock_o(lock), .phase_o(phase)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
      end
   endtask

   task automatic step(input logic b, input int k);
      for (int j = 0; j < NPH; j++) samp[j] = (j < k) ? prev_bit : b;
      @(posedge clk);
      cyc++;
      bits_h[cyc] = b;
      prev_bit = b;
      @(negedge clk);
   endtask

   task automatic observe();
      if (cyc < lock_at) begin
         check(lock == 1'b0, "R3", int'(lock), 0, "lock before run complete");
         check(sdo == 1'b0, "R6", int'(sdo), 0, "data before lock");
      end else begin
         check(lock == 1'b1, (cyc == lock_at) ? "R3" : "R7", int'(lock), 1, "lock level");
         check(int'(phase) == exp_ph, (cyc == lock_at) ? "R2" : "R8", int'(phase), exp_ph, "phase");
         check(sdo == bits_h[cyc-PS-dly], "R5", int'(sdo), int'(bits_h[cyc-PS-dly]), "payload bit");
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      samp = '0;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      cyc = 0;
      prev_bit = 1'b0;
      bits_h[0] = 1'b0;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd == 20000) begin
         errs++;
         checks++;
         $display("FAIL R3 watchdog: actual=%0d expected=%0d", wd, 0);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      // R1: state after power-up reset
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(lock == 1'b0, "R1", int'(lock), 0, "reset lock");
      check(sdo == 1'b0, "R1", int'(sdo), 0, "reset data");
      check(phase == '0, "R1", int'(phase), 0, "reset phase");

      // Table walk: every sub-bit offset, 13-bit preamble, then payload (R2 R3 R5 R9)
      for (int e = 0; e < 8; e++) begin
         int k;
         do_reset();
         k = OFF_TAB[e][0];
         exp_ph = OFF_TAB[e][1];
         dly = OFF_TAB[e][2];
         lock_at = P0 + RUN - 1 + 1 + PS;
         for (int i = 0; i < 3; i++) begin step(1'b0, k); observe(); end
         for (int i = 0; i < 13; i++) begin step(((i % 2) == 0), k); observe(); end
         lfsr = 16'hACE1 ^ 16'(e * 97);
         for (int i = 0; i < 24; i++) begin
            step(lfsr[0], k);
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
            observe();
         end
      end

      // R4: far edge restarts the run at the new position
      do_reset();
      exp_ph = 1; dly = 1; lock_at = 9 + RUN - 1 + 1 + PS;
      for (int i = 0; i < 3; i++) begin step(1'b0, 1); observe(); end
      for (int i = 0; i < 5; i++) begin step(((i % 2) == 0), 1); observe(); end
      for (int i = 5; i < 28; i++) begin step(((i % 2) == 0), 5); observe(); end

      // R4: a missing transition restarts the count
      do_reset();
      exp_ph = 7; dly = 0; lock_at = 11 + RUN - 1 + 1 + PS;
      for (int i = 0; i < 3; i++) begin step(1'b0, 3); observe(); end
      for (int i = 0; i < 6; i++) begin step(((i % 2) == 0), 3); observe(); end
      step(1'b0, 3); observe();
      for (int i = 0; i < 22; i++) begin step(((i % 2) == 0), 3); observe(); end

      // R9: tolerance across the 7/0 wrap, last edge at 0
      do_reset();
      exp_ph = 4; dly = 0; lock_at = P0 + RUN - 1 + 1 + PS;
      for (int i = 0; i < 3; i++) begin step(1'b0, 0); observe(); end
      for (int i = 0; i < 12; i++) begin step(((i % 2) == 0), ((i % 2) == 0) ? 7 : 0); observe(); end
      for (int i = 12; i < 30; i++) begin step(((i % 3) != 1), 0); observe(); end

      // R3 R8: jittered edges inside tolerance lock; later drift leaves phase alone
      do_reset();
      exp_ph = 7; dly = 0; lock_at = P0 + RUN - 1 + 1 + PS;
      for (int i = 0; i < 3; i++) begin step(1'b0, 3); observe(); end
      for (int i = 0; i < 12; i++) begin
         int kj;
         kj = ((i % 3) == 0) ? 3 : (((i % 3) == 1) ? 4 : 2);
         if (i == 11) kj = 3;
         step(((i % 2) == 0), kj);
         observe();
      end
      for (int i = 12; i < 36; i++) begin step(((i % 2) == 0), ((i % 2) == 0) ? 2 : 3); observe(); end

      // R1: reset while locked clears everything; a short preamble then does not relock
      rst = 1'b1;
      samp = 8'hF0;
      @(posedge clk);
      @(negedge clk);
      check(lock == 1'b0, "R1", int'(lock), 0, "mid-burst reset lock");
      check(sdo == 1'b0, "R1", int'(sdo), 0, "mid-burst reset data");
      check(phase == '0, "R1", int'(phase), 0, "mid-burst reset phase");
      rst = 1'b0;
      cyc = 0;
      prev_bit = 1'b0;
      lock_at = 1000;
      for (int i = 0; i < 8; i++) begin step(((i % 2) == 0), 2); observe(); end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule